// File: doc/BRIEF.md
# Dual-Port Write-Back Data Cache

This block is a direct-mapped, write-back data cache placed between a pipelined CPU core and a pipelined memory bus. It offers the core two request ports on one shared tag and data array. Port A may read or write. Port B only reads. A read that hits returns its word on the clock after acceptance. A write that hits is taken in the cycle it is offered and only marks the line dirty. Memory is updated when that line is evicted or flushed.

Each port is a valid/ready request channel. A requester raises `*_req_valid` with a stable address (and write data), and holds it until it sees `*_req_ready` high at a clock edge. That edge is the acceptance. Read data comes back on `*_rvalid` / `*_rdata` one cycle later, with no back-pressure on the return. A port whose request misses simply sees `ready` low until the line has been fetched, and the same request then hits.

Only one miss is serviced at a time: optional write-back of a dirty victim, then an 8-word refill, both as pipelined bursts. A `flush_req` pulse walks every line, writes back the dirty ones, and ends with a one-cycle `flush_done`.

Top module: `dcache_dp`

## Requirements
- R1: After reset every line is invalid and the bus is idle (`m_cyc` = 0, `flush_done` = 0, no `rvalid`), so the first request to any address sees `ready` low.
- R2: A read accepted on either port produces `rvalid` with the correct word exactly one clock after acceptance, and a repeated read of a fetched line is accepted without wait.
- R3: A write to a resident line on port A sees `a_req_ready` high in the cycle it is presented, and no bus cycle is started.
- R4: A write hit changes only the cache. Memory keeps its old value until that line is written back by eviction or flush.
- R5: When port A writes a word and port B reads the same word in the same cycle, port B returns the newly written value.
- R6: A miss whose victim line is valid and dirty first writes the victim's 8 words at ascending offsets 0..7 to the victim's own address. It then reads the 8 words of the new line at ascending offsets, after which the stalled request is accepted and returns the new data. Address = {tag, index, offset} with offset in bits [2:0] and index in bits [IW+2:3].
- R7: When both ports miss in the same cycle, port A's line is fetched first.
- R8: A read hit on port B is accepted in the same cycle in which a miss on port A is detected.
- R9: A flush writes back every valid dirty line exactly once, clears its dirty bit so that a second flush issues no bus writes, keeps lines valid, and ends with a `flush_done` pulse one cycle wide.
- R10: From the cycle `flush_req` is seen until `flush_done`, neither port accepts a request.
- R11: On the memory bus `m_stb` is only high together with `m_cyc`, and while a strobe is stalled its address and direction stay unchanged.
- R12: `rvalid` on a port is never raised for a request that has not been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req_valid | input | 1 | Port A request present |
| a_req_ready | output | 1 | Port A request accepted this cycle |
| a_we | input | 1 | Port A request is a write |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rvalid | output | 1 | Port A read data valid |
| a_rdata | output | DW | Port A read data |
| b_req_valid | input | 1 | Port B read request present |
| b_req_ready | output | 1 | Port B request accepted this cycle |
| b_addr | input | AW | Port B word address |
| b_rvalid | output | 1 | Port B read data valid |
| b_rdata | output | DW | Port B read data |
| flush_req | input | 1 | Start a flush (pulse) |
| flush_done | output | 1 | Flush finished (one-cycle pulse) |
| m_cyc | output | 1 | Bus cycle active |
| m_stb | output | 1 | Bus strobe |
| m_we | output | 1 | Bus write |
| m_adr | output | AW | Bus word address |
| m_dat_o | output | DW | Bus write data |
| m_dat_i | input | DW | Bus read data |
| m_ack | input | 1 | Bus acknowledge |
| m_stall | input | 1 | Bus cannot take the strobe |

## Verification
A wrong valid bit or tag shows up at once as a port whose `ready` stays low on a resident line, or as a read returning another line's data on the next `rvalid`. A wrong dirty bit stays hidden until that line leaves the cache. It then shows as a missing or extra 8-beat write burst on eviction or flush, or as a stale word in memory after it. The bench therefore checks memory contents and bus write counts right after each eviction and flush, not only the data returned to the core. A lost forward between ports appears on the single B read that follows a same-word write.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_WB,
    ST_RF,
    ST_FDONE
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int SETS = 16,
  parameter int TW   = 5,
  localparam int IW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] a_idx,
  input  logic [TW-1:0] a_tag,
  output logic          a_hit,
  input  logic [IW-1:0] b_idx,
  input  logic [TW-1:0] b_tag,
  output logic          b_hit,
  input  logic [IW-1:0] v_idx,
  output logic [TW-1:0] v_tag,
  output logic          v_valid,
  output logic          v_dirty,
  input  logic          set_dirty,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_dirty,
  input  logic          install,
  input  logic [TW-1:0] install_tag
);
  logic [TW-1:0] tag_q [SETS];
  logic [SETS-1:0] vld_q, drt_q;

  assign a_hit   = vld_q[a_idx] && (tag_q[a_idx] == a_tag);
  assign b_hit   = vld_q[b_idx] && (tag_q[b_idx] == b_tag);
  assign v_tag   = tag_q[v_idx];
  assign v_valid = vld_q[v_idx];
  assign v_dirty = drt_q[v_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
      for (int i = 0; i < SETS; i++) tag_q[i] <= '0;
    end else begin
      if (install) begin
        tag_q[v_idx] <= install_tag;
        vld_q[v_idx] <= 1'b1;
        drt_q[v_idx] <= 1'b0;
      end
      if (clr_dirty) drt_q[v_idx] <= 1'b0;
      if (set_dirty) drt_q[set_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/dc_data_ram.sv
module dc_data_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int RAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           ra_en,
  input  logic [RAW-1:0] ra_addr,
  output logic [DW-1:0]  ra_data,
  input  logic           rb_en,
  input  logic [RAW-1:0] rb_addr,
  output logic [DW-1:0]  rb_data,
  input  logic [RAW-1:0] rf_addr,
  output logic [DW-1:0]  rf_data
);
  logic [DW-1:0] mem [DEPTH];

  assign rf_data = mem[rf_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (ra_en) ra_data <= mem[ra_addr];
    if (rb_en) rb_data <= (wr_en && wr_addr == rb_addr) ? wr_data : mem[rb_addr];
  end
endmodule

// File: rtl/dc_miss_ctrl.sv
module dc_miss_ctrl
  import dc_pkg::*;
#(
  parameter int AW     = 12,
  parameter int SETS   = 16,
  parameter int LINE_W = 8,
  localparam int OW    = $clog2(LINE_W),
  localparam int IW    = $clog2(SETS),
  localparam int TW    = AW - OW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_miss,
  input  logic [IW-1:0] a_idx,
  input  logic [TW-1:0] a_tag,
  input  logic          b_miss,
  input  logic [IW-1:0] b_idx,
  input  logic [TW-1:0] b_tag,
  input  logic          flush_req,
  input  logic [TW-1:0] v_tag,
  input  logic          v_valid,
  input  logic          v_dirty,
  output logic          idle,
  output logic          flush_done,
  output logic [IW-1:0] line,
  output logic [OW-1:0] wb_off,
  output logic [OW-1:0] fill_off,
  output logic          fill_we,
  output logic          install,
  output logic [TW-1:0] install_tag,
  output logic          clr_dirty,
  output logic          m_cyc,
  output logic          m_stb,
  output logic          m_we,
  output logic [AW-1:0] m_adr,
  input  logic          m_ack,
  input  logic          m_stall
);
  dc_state_e   st;
  logic        fl;
  logic [TW-1:0] ntag;
  logic [OW:0]   iss;
  logic [OW-1:0] ackc;
  logic          last_ack;

  assign idle        = (st == ST_IDLE);
  assign flush_done  = (st == ST_FDONE);
  assign m_cyc       = (st == ST_WB) || (st == ST_RF);
  assign m_stb       = m_cyc && !iss[OW];
  assign m_we        = (st == ST_WB);
  assign wb_off      = iss[OW-1:0];
  assign fill_off    = ackc;
  assign m_adr       = {(st == ST_WB) ? v_tag : ntag, line, iss[OW-1:0]};
  assign last_ack    = m_ack && (&ackc);
  assign fill_we     = (st == ST_RF) && m_ack;
  assign install     = (st == ST_RF) && last_ack;
  assign install_tag = ntag;
  assign clr_dirty   = (st == ST_WB) && fl && last_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      fl   <= 1'b0;
      line <= '0;
      ntag <= '0;
      iss  <= '0;
      ackc <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (flush_req) begin
            fl <= 1'b1; line <= '0; st <= ST_CHK;
          end else if (a_miss) begin
            fl <= 1'b0; line <= a_idx; ntag <= a_tag; st <= ST_CHK;
          end else if (b_miss) begin
            fl <= 1'b0; line <= b_idx; ntag <= b_tag; st <= ST_CHK;
          end
        end
        ST_CHK: begin
          iss  <= '0;
          ackc <= '0;
          if (v_valid && v_dirty) st <= ST_WB;
          else if (!fl) st <= ST_RF;
          else if (&line) st <= ST_FDONE;
          else line <= line + 1'b1;
        end
        ST_WB, ST_RF: begin
          if (m_stb && !m_stall) iss <= iss + 1'b1;
          if (m_ack) ackc <= ackc + 1'b1;
          if (last_ack) begin
            iss <= '0;
            if (st == ST_RF) st <= ST_IDLE;
            else if (!fl) st <= ST_RF;
            else if (&line) st <= ST_FDONE;
            else begin
              line <= line + 1'b1;
              st   <= ST_CHK;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_dp.sv
module dcache_dp #(
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int SETS   = 16,
  parameter int LINE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req_valid,
  output logic          a_req_ready,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic          a_rvalid,
  output logic [DW-1:0] a_rdata,
  input  logic          b_req_valid,
  output logic          b_req_ready,
  input  logic [AW-1:0] b_addr,
  output logic          b_rvalid,
  output logic [DW-1:0] b_rdata,
  input  logic          flush_req,
  output logic          flush_done,
  output logic          m_cyc,
  output logic          m_stb,
  output logic          m_we,
  output logic [AW-1:0] m_adr,
  output logic [DW-1:0] m_dat_o,
  input  logic [DW-1:0] m_dat_i,
  input  logic          m_ack,
  input  logic          m_stall
);
  localparam int OW  = $clog2(LINE_W);
  localparam int IW  = $clog2(SETS);
  localparam int TW  = AW - OW - IW;
  localparam int RAW = OW + IW;

  logic a_hit, b_hit, ctl_idle, v_valid, v_dirty, fill_we, install, clr_dirty;
  logic a_fire, b_fire, a_wfire;
  logic [TW-1:0] v_tag, install_tag;
  logic [IW-1:0] line;
  logic [OW-1:0] wb_off, fill_off;
  logic [RAW-1:0] wr_addr;
  logic [DW-1:0]  wr_data;

  assign a_req_ready = ctl_idle && !flush_req && a_hit;
  assign b_req_ready = ctl_idle && !flush_req && b_hit;
  assign a_fire  = a_req_valid && a_req_ready;
  assign b_fire  = b_req_valid && b_req_ready;
  assign a_wfire = a_fire && a_we;
  assign wr_addr = fill_we ? {line, fill_off} : a_addr[RAW-1:0];
  assign wr_data = fill_we ? m_dat_i : a_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
    end else begin
      a_rvalid <= a_fire && !a_we;
      b_rvalid <= b_fire;
    end
  end

  dc_tag_store #(.SETS(SETS), .TW(TW)) u_tags (
    .clk, .rst_n,
    .a_idx(a_addr[RAW-1:OW]), .a_tag(a_addr[AW-1:RAW]), .a_hit,
    .b_idx(b_addr[RAW-1:OW]), .b_tag(b_addr[AW-1:RAW]), .b_hit,
    .v_idx(line), .v_tag, .v_valid, .v_dirty,
    .set_dirty(a_wfire), .set_idx(a_addr[RAW-1:OW]),
    .clr_dirty, .install, .install_tag
  );

  dc_data_ram #(.DEPTH(SETS * LINE_W), .DW(DW)) u_ram (
    .clk,
    .wr_en(fill_we || a_wfire), .wr_addr, .wr_data,
    .ra_en(a_fire && !a_we), .ra_addr(a_addr[RAW-1:0]), .ra_data(a_rdata),
    .rb_en(b_fire), .rb_addr(b_addr[RAW-1:0]), .rb_data(b_rdata),
    .rf_addr({line, wb_off}), .rf_data(m_dat_o)
  );

  dc_miss_ctrl #(.AW(AW), .SETS(SETS), .LINE_W(LINE_W)) u_ctl (
    .clk, .rst_n,
    .a_miss(a_req_valid && !a_hit), .a_idx(a_addr[RAW-1:OW]), .a_tag(a_addr[AW-1:RAW]),
    .b_miss(b_req_valid && !b_hit), .b_idx(b_addr[RAW-1:OW]), .b_tag(b_addr[AW-1:RAW]),
    .flush_req, .v_tag, .v_valid, .v_dirty,
    .idle(ctl_idle), .flush_done, .line, .wb_off, .fill_off, .fill_we,
    .install, .install_tag, .clr_dirty,
    .m_cyc, .m_stb, .m_we, .m_adr, .m_ack, .m_stall
  );
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_req_valid,
  input logic          a_req_ready,
  input logic          a_we,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic          a_rvalid,
  input logic          b_req_valid,
  input logic          b_req_ready,
  input logic [AW-1:0] b_addr,
  input logic          b_rvalid,
  input logic [DW-1:0] b_rdata,
  input logic          flush_req,
  input logic          flush_done,
  input logic          ctl_idle,
  input logic          m_cyc,
  input logic          m_stb,
  input logic          m_we,
  input logic [AW-1:0] m_adr,
  input logic          m_stall
);
  logic in_fl;
  always_ff @(posedge clk) begin
    if (!rst_n) in_fl <= 1'b0;
    else if (flush_done) in_fl <= 1'b0;
    else if (flush_req && ctl_idle) in_fl <= 1'b1;
  end

  AST_A_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req_valid && a_req_ready && !a_we) |=> a_rvalid); // R2
  AST_B_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req_valid && b_req_ready) |=> b_rvalid); // R2
  AST_WRHIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req_valid && a_req_ready && a_we) |-> !m_cyc); // R3
  AST_FWD_NEW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req_valid && a_req_ready && a_we && b_req_valid && b_req_ready && a_addr == b_addr)
    |=> (b_rdata == $past(a_wdata))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done); // R9
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fl |-> (!a_req_ready && !b_req_ready)); // R10
  AST_STB_IN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    m_stb |-> m_cyc); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_stb && m_stall) |=> (m_stb && $stable(m_adr) && $stable(m_we))); // R11
  AST_RVALID_ONLY_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    a_rvalid |-> $past(a_req_valid && a_req_ready && !a_we)); // R12
endmodule

bind dcache_dp dc_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk, .rst_n, .a_req_valid, .a_req_ready, .a_we, .a_addr, .a_wdata, .a_rvalid,
  .b_req_valid, .b_req_ready, .b_addr, .b_rvalid, .b_rdata,
  .flush_req, .flush_done, .ctl_idle,
  .m_cyc, .m_stb, .m_we, .m_adr, .m_stall
);

// File: tb/tb_dcache_dp.sv
module tb_dcache_dp;
  localparam int CLK_P = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int MW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic a_req_valid = 0, a_we = 0, b_req_valid = 0, flush_req = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0;
  logic a_req_ready, a_rvalid, b_req_ready, b_rvalid, flush_done;
  logic [DW-1:0] a_rdata, b_rdata, m_dat_o;
  logic m_cyc, m_stb, m_we;
  logic [AW-1:0] m_adr;
  logic [DW-1:0] m_dat_i = '0;
  logic m_ack = 0, m_stall = 0;

  always #(CLK_P/2) clk = ~clk;

  dcache_dp dut (.*);

  logic [DW-1:0] backing [MW];
  logic [DW-1:0] exp_mem [MW];
  logic [DW-1:0] q [16];
  logic [AW-1:0] wlog [64];
  logic [AW-1:0] rlog [64];
  int qh = 0, qt = 0, wr_cnt = 0, rd_cnt = 0, proto_err = 0;
  int tests = 0, fails = 0;
  bit pst_stb = 0;
  logic [AW-1:0] pst_adr = '0;

  initial for (int i = 0; i < MW; i++) begin
    backing[i] = 32'hA500_0000 | i;
    exp_mem[i] = 32'hA500_0000 | i;
  end

  // memory model: pipelined, random stall and ack delay
  always @(posedge clk) begin
    if (!rst_n) begin
      qh = 0; qt = 0; m_ack <= 0; m_stall <= 0; pst_stb = 0;
    end else begin
      if (m_stb && !m_cyc) proto_err++;
      if (pst_stb && (!m_stb || m_adr != pst_adr)) proto_err++;
      pst_stb = m_stb && m_stall;
      pst_adr = m_adr;
      if (qh != qt && $urandom_range(2) != 0) begin
        m_ack <= 1; m_dat_i <= q[qh % 16]; qh++;
      end else m_ack <= 0;
      if (m_stb && !m_stall) begin
        if (m_we) begin
          backing[m_adr] = m_dat_o; wlog[wr_cnt % 64] = m_adr; wr_cnt++; q[qt % 16] = '0;
        end else begin
          q[qt % 16] = backing[m_adr]; rlog[rd_cnt % 64] = m_adr; rd_cnt++;
        end
        qt++;
      end
      m_stall <= ($urandom_range(3) == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_pair(input bit ae, input bit awe, input logic [AW-1:0] aad,
                          input logic [DW-1:0] awd, input bit be, input logic [AW-1:0] bad,
                          input string req, output int aw, output int bw);
    bit apend, bpend, af, bf;
    logic [DW-1:0] aexp, bexp;
    aexp = '0; bexp = '0;
    @(negedge clk);
    a_req_valid = ae; a_we = awe; a_addr = aad; a_wdata = awd;
    b_req_valid = be; b_addr = bad;
    apend = ae; bpend = be; aw = 0; bw = 0;
    while (apend || bpend) begin
      #1;
      af = apend && a_req_ready;
      bf = bpend && b_req_ready;
      if (af) begin
        if (awe) exp_mem[aad] = awd; else aexp = exp_mem[aad];
      end
      if (bf) bexp = exp_mem[bad];
      if (apend && !af) aw++;
      if (bpend && !bf) bw++;
      @(negedge clk);
      if (af) begin
        a_req_valid = 0; apend = 0;
        if (!awe) begin
          check(a_rvalid, "R2", "A rvalid one cycle after accept", 32'(a_rvalid), 1);
          check(a_rdata == aexp, req, "A read data", a_rdata, aexp);
        end
      end else if (apend && a_rvalid) check(0, "R12", "A rvalid before accept", 1, 0);
      if (bf) begin
        b_req_valid = 0; bpend = 0;
        check(b_rvalid, "R2", "B rvalid one cycle after accept", 32'(b_rvalid), 1);
        check(b_rdata == bexp, req, "B read data", b_rdata, bexp);
      end else if (bpend && b_rvalid) check(0, "R12", "B rvalid before accept", 1, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!m_cyc && !flush_done && !a_rvalid && !b_rvalid, "R1", "idle outputs in reset", 32'(m_cyc), 0);
    rst_n = 1;
    @(negedge clk);
    a_req_valid = 1; a_addr = 12'h010;
    #1;
    check(!a_req_ready, "R1", "empty cache refuses first request", 32'(a_req_ready), 0);
    a_req_valid = 0;
  endtask

  task automatic t_read_hits();
    int aw, bw, rc;
    rc = rd_cnt;
    run_pair(1, 0, 12'h010, 0, 0, 0, "R6", aw, bw);
    check(aw > 0, "R1", "cold read waits", aw, 1);
    check(rd_cnt - rc == 8, "R6", "refill burst length", rd_cnt - rc, 8);
    run_pair(1, 0, 12'h013, 0, 0, 0, "R2", aw, bw);
    check(aw == 0, "R2", "A read hit no wait", aw, 0);
    run_pair(0, 0, 0, 0, 1, 12'h017, "R2", aw, bw);
    check(bw == 0, "R2", "B read hit no wait", bw, 0);
  endtask

  task automatic t_write_hit();
    int aw, bw, wc;
    wc = wr_cnt;
    run_pair(1, 1, 12'h012, 32'hDEAD0001, 0, 0, "R3", aw, bw);
    check(aw == 0, "R3", "write hit no stall", aw, 0);
    check(wr_cnt == wc, "R4", "no bus write on write hit", wr_cnt - wc, 0);
    check(backing[12'h012] == 32'hA500_0012, "R4", "memory unchanged", backing[12'h012], 32'hA500_0012);
    run_pair(0, 0, 0, 0, 1, 12'h012, "R2", aw, bw);
  endtask

  task automatic t_conflict();
    int aw, bw;
    run_pair(1, 1, 12'h014, 32'hBEEF0002, 1, 12'h014, "R5", aw, bw);
    check(aw == 0 && bw == 0, "R5", "both accepted same cycle", aw + bw, 0);
  endtask

  task automatic t_evict();
    int aw, bw, wc;
    wc = wr_cnt;
    run_pair(1, 0, 12'h090, 0, 0, 0, "R6", aw, bw);
    check(wr_cnt - wc == 8, "R6", "victim burst length", wr_cnt - wc, 8);
    for (int k = 0; k < 8; k++)
      check(wlog[(wc + k) % 64] == AW'(12'h010 + k), "R6", "victim address order",
            32'(wlog[(wc + k) % 64]), 32'h010 + k);
    check(backing[12'h012] == 32'hDEAD0001, "R4", "written word reaches memory", backing[12'h012], 32'hDEAD0001);
    check(backing[12'h014] == 32'hBEEF0002, "R4", "forwarded word reaches memory", backing[12'h014], 32'hBEEF0002);
    run_pair(1, 0, 12'h012, 0, 0, 0, "R6", aw, bw);
    check(aw > 0, "R6", "re-fetch after eviction waits", aw, 1);
  endtask

  task automatic t_both_miss();
    int aw, bw, rc;
    rc = rd_cnt;
    run_pair(1, 0, 12'h120, 0, 1, 12'h238, "R7", aw, bw);
    check(rlog[rc % 64] == 12'h120, "R7", "A line fetched first", 32'(rlog[rc % 64]), 32'h120);
    check(rlog[(rc + 8) % 64] == 12'h238, "R7", "B line fetched second", 32'(rlog[(rc + 8) % 64]), 32'h238);
    check(aw < bw, "R7", "A accepted before B", aw, bw);
  endtask

  task automatic t_b_during_a_miss();
    int aw, bw;
    run_pair(1, 0, 12'h300, 0, 1, 12'h23A, "R8", aw, bw);
    check(bw == 0, "R8", "B hit accepted while A misses", bw, 0);
    check(aw > 0, "R8", "A waits on its miss", aw, 1);
  endtask

  task automatic do_flush(output int nwr);
    int wc, guard;
    wc = wr_cnt; guard = 0;
    @(negedge clk);
    flush_req = 1; a_req_valid = 1; a_we = 0; a_addr = 12'h300;
    #1;
    check(!a_req_ready, "R10", "no accept with flush_req", 32'(a_req_ready), 0);
    @(negedge clk);
    flush_req = 0;
    while (!flush_done && guard < 2000) begin
      #1;
      if (a_req_ready) check(0, "R10", "accept during flush", 1, 0);
      @(negedge clk);
      guard++;
    end
    a_req_valid = 0;
    check(flush_done, "R9", "flush_done seen", 32'(flush_done), 1);
    @(negedge clk);
    check(!flush_done, "R9", "flush_done one cycle", 32'(flush_done), 0);
    check(!a_rvalid, "R10", "held request not served in flush", 32'(a_rvalid), 0);
    nwr = wr_cnt - wc;
  endtask

  task automatic t_flush();
    int aw, bw, n;
    run_pair(1, 1, 12'h300, 32'h11110001, 0, 0, "R3", aw, bw);
    run_pair(1, 1, 12'h125, 32'h22220002, 0, 0, "R3", aw, bw);
    run_pair(1, 1, 12'h011, 32'h33330003, 0, 0, "R3", aw, bw);
    do_flush(n);
    check(n == 24, "R9", "three dirty lines written", n, 24);
    check(backing[12'h300] == 32'h11110001, "R9", "line 0 flushed", backing[12'h300], 32'h11110001);
    check(backing[12'h125] == 32'h22220002, "R9", "line 4 flushed", backing[12'h125], 32'h22220002);
    check(backing[12'h011] == 32'h33330003, "R9", "line 2 flushed", backing[12'h011], 32'h33330003);
    do_flush(n);
    check(n == 0, "R9", "second flush writes nothing", n, 0);
    run_pair(1, 0, 12'h300, 0, 0, 0, "R9", aw, bw);
    check(aw == 0, "R9", "line still valid after flush", aw, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_read_hits();
    t_write_hit();
    t_conflict();
    t_evict();
    t_both_miss();
    t_b_during_a_miss();
    t_flush();
    check(proto_err == 0, "R11", "bus strobe/stall rules", proto_err, 0);
    summary();
  end
endmodule